// File: doc/BRIEF.md
# Five-Channel Buffered PWM Timer Bank

A bank of five down-counting timers, each driving one pulse-width output, controlled through a 32-bit register port with byte addresses. Every timer has a period buffer and a threshold buffer that software may rewrite at any time. Their contents reach the working counter and working threshold only at defined moments: either while the timer's load bit is held, or on the automatic refill that follows the counter reaching zero. This way a new period never tears the one in progress.

Start, load, polarity, refill and (for timer 0 only) a dead-band enable bit for all five timers are packed into one shared control word. A status word collects one zero-reached flag per timer, each cleared by writing a one to it. To stop a timer gracefully, software clears only its refill bit: the timer finishes the period it is in and then halts with its output at the idle level. Two configuration words exist as plain storage for a clock-divider stage that lives elsewhere.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0, every counter is stopped and every output is 0.
- R2: The control word at 0x08 places timer 0's field at bit 0 and timer n≥1 at bit 4·(n+1). Within a field, +0 is run, +1 is load, +2 is invert and +3 is refill. Bit 4 (dead-band, timer 0 only) is also stored. All other bits read 0, so writing all ones reads back 0x00FFFF1F.
- R3: Timer n has its period buffer at 0x0C+12n and its threshold buffer at 0x10+12n. In every clock where its load bit is 1, both buffers are copied into the working registers and the counter does not count, even with run set.
- R4: With run=1, load=0 and the timer armed by a prior load, the counter steps down by one per clock. From zero with refill set, it takes both buffers on the next clock, so the period is the period buffer plus one clocks.
- R5: The output before inversion is 1 while the timer is counting and its count is at or below the working threshold, and 0 otherwise (including whenever the timer is stopped or held). The invert bit complements it.
- R6: A timer whose refill bit is cleared while counting runs down to zero, spends that one clock at zero, then stops, holding count 0 and the idle output level.
- R7: Buffer writes during a running period do not change the working count or threshold until the next refill.
- R8: Bit n of the status word at 0x44 is set on every clock at which a counting timer n is at zero. Writing a 1 to bit n clears it, and writing 0 leaves it alone.
- R9: The observation address 0x14+12n returns the live working count, and writes to it are ignored. For timer 4 that address coincides with 0x44, where the status word takes precedence.
- R10: Words at 0x00 and 0x04 store and return all 32 bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 8 | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| pwm_out | output | 5 | One pulse-width output per timer |

## Verification
The assertions take for granted that an address is only ever driven with a write strobe for a whole clock and that a timer's working state is meaningful only after a load has armed it. The checks on a held timer also assume that the control word is not rewritten in the same clock as a stop or zero-crossing they are examining. The bench drives every write as a single clock-wide strobe set up half a period before the edge. It always arms a timer with the two-step load-then-run sequence, and it rewrites the control word only at clocks where the timers under observation are not at the edge being checked. It sweeps small period and threshold values across all five timers and both polarities, so that the counting and refill checks see every relative order of count and threshold, including a threshold above the period.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NT = 5,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [NT-1:0] pwm_out
);
  localparam logic [7:0] A_CFG0 = 8'h00;
  localparam logic [7:0] A_CFG1 = 8'h04;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h44;

  function automatic int fbase(int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m;
    m = 32'h1F;
    for (int n = 1; n < NT; n++) m[fbase(n) +: 4] = 4'hF;
    return m;
  endfunction

  localparam logic [31:0] CMASK = ctrl_mask();

  logic [31:0] cfg0_q, cfg1_q, ctrl_q;
  logic [NT-1:0] irq_q;
  logic [NT-1:0] b_run, b_load, b_inv, b_refill;
  logic [NT-1:0] live_all, counting, at_zero;
  logic [NT-1:0][CW-1:0] cntb_all, cmpb_all, cnt_all, cmp_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      ctrl_q <= '0;
      irq_q  <= '0;
    end else begin
      if (wr_en && addr == A_CFG0) cfg0_q <= wdata;
      if (wr_en && addr == A_CFG1) cfg1_q <= wdata;
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata & CMASK;
      irq_q <= (irq_q & ~((wr_en && addr == A_STAT) ? wdata[NT-1:0] : '0)) | at_zero;
    end
  end

  for (genvar n = 0; n < NT; n++) begin : g_tmr
    localparam logic [7:0] A_PER = 8'(12 + 12 * n);
    localparam logic [7:0] A_THR = 8'(16 + 12 * n);
    logic [CW-1:0] per_q, thr_q, cnt_q, cmp_q;
    logic live_q;

    assign b_run[n]    = ctrl_q[fbase(n)];
    assign b_load[n]   = ctrl_q[fbase(n) + 1];
    assign b_inv[n]    = ctrl_q[fbase(n) + 2];
    assign b_refill[n] = ctrl_q[fbase(n) + 3];
    assign counting[n] = b_run[n] & ~b_load[n] & live_q;
    assign at_zero[n]  = counting[n] && cnt_q == '0;
    assign pwm_out[n]  = (counting[n] && cnt_q <= cmp_q) ^ b_inv[n];

    assign cntb_all[n] = per_q;
    assign cmpb_all[n] = thr_q;
    assign cnt_all[n]  = cnt_q;
    assign cmp_all[n]  = cmp_q;
    assign live_all[n] = live_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_q  <= '0;
        thr_q  <= '0;
        cnt_q  <= '0;
        cmp_q  <= '0;
        live_q <= 1'b0;
      end else begin
        if (wr_en && addr == A_PER) per_q <= wdata[CW-1:0];
        if (wr_en && addr == A_THR) thr_q <= wdata[CW-1:0];
        if (b_load[n]) begin
          cnt_q  <= per_q;
          cmp_q  <= thr_q;
          live_q <= 1'b1;
        end else if (counting[n]) begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (b_refill[n]) begin
            cnt_q <= per_q;
            cmp_q <= thr_q;
          end else begin
            live_q <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NT; n++) begin
      if (addr == 8'(12 + 12 * n)) rdata = 32'(cntb_all[n]);
      if (addr == 8'(16 + 12 * n)) rdata = 32'(cmpb_all[n]);
      if (addr == 8'(20 + 12 * n)) rdata = 32'(cnt_all[n]);
    end
    if (addr == A_CFG0) rdata = cfg0_q;
    if (addr == A_CFG1) rdata = cfg1_q;
    if (addr == A_CTRL) rdata = ctrl_q;
    if (addr == A_STAT) rdata = 32'(irq_q);
  end
endmodule

module pwm_bank_chk #(
  parameter int NT = 5,
  parameter int CW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [NT-1:0]         b_run,
  input logic [NT-1:0]         b_load,
  input logic [NT-1:0]         b_inv,
  input logic [NT-1:0]         b_refill,
  input logic [NT-1:0]         live_all,
  input logic [NT-1:0]         irq_q,
  input logic [NT-1:0]         pwm_out,
  input logic [NT-1:0][CW-1:0] cntb_all,
  input logic [NT-1:0][CW-1:0] cmpb_all,
  input logic [NT-1:0][CW-1:0] cnt_all,
  input logic [NT-1:0][CW-1:0] cmp_all
);
  logic [NT-1:0] act;
  assign act = b_run & ~b_load & live_all;

  for (genvar n = 0; n < NT; n++) begin : g_chk
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      b_load[n] |=> (cnt_all[n] == $past(cntb_all[n]) && cmp_all[n] == $past(cmpb_all[n]))); // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (act[n] && cnt_all[n] != '0) |=> cnt_all[n] == CW'($past(cnt_all[n]) - 1'b1)); // R4
    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (act[n] && cnt_all[n] == '0 && b_refill[n]) |=> cnt_all[n] == $past(cntb_all[n])); // R4
    AST_ZERO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (act[n] && cnt_all[n] == '0) |-> pwm_out[n] != b_inv[n]); // R5
    AST_GRACEFUL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (act[n] && cnt_all[n] == '0 && !b_refill[n] && !wr_en) |=> (cnt_all[n] == '0 && pwm_out[n] == b_inv[n])); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (act[n] && cnt_all[n] == '0) |=> irq_q[n]); // R8
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NT(NT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .b_run(b_run), .b_load(b_load), .b_inv(b_inv), .b_refill(b_refill),
  .live_all(live_all), .irq_q(irq_q), .pwm_out(pwm_out),
  .cntb_all(cntb_all), .cmpb_all(cmpb_all), .cnt_all(cnt_all), .cmp_all(cmp_all)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0] pwm_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_bank u_pwm_bank (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                       .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  function automatic int fb(int t);
    return (t == 0) ? 0 : 4 * (t + 1);
  endfunction
  function automatic logic [7:0] a_per(int t); return 8'(12 + 12 * t); endfunction
  function automatic logic [7:0] a_thr(int t); return 8'(16 + 12 * t); endfunction
  function automatic logic [7:0] a_obs(int t); return 8'(20 + 12 * t); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (v[i]) ; // no-op
    rd(8'h00, v); chk("R1 cfg0", v, 0);
    rd(8'h08, v); chk("R1 ctrl", v, 0);
    rd(8'h44, v); chk("R1 status", v, 0);
    rd(a_per(2), v); chk("R1 period buffer", v, 0);
    rd(a_obs(1), v); chk("R1 count", v, 0);
    chk("R1 outputs", 32'(pwm_out), 0);

    // R10 configuration storage
    wr(8'h00, 32'hA5C3_0F96); wr(8'h04, 32'h1234_FEDC);
    rd(8'h00, v); chk("R10 cfg0", v, 32'hA5C3_0F96);
    rd(8'h04, v); chk("R10 cfg1", v, 32'h1234_FEDC);

    // R2 control packing
    mask = 32'h10;
    for (int t = 0; t < 5; t++) mask |= 32'hF << fb(t);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R2 control mask", v, mask);
    wr(8'h08, 0);

    // R3 buffers held off until load; R9 observation is read-only
    wr(a_per(0), 9); wr(a_thr(0), 2); tick; tick;
    rd(a_obs(0), v); chk("R3 no load without load bit", v, 0);
    wr(8'h08, 32'h2); tick;
    rd(a_obs(0), v); chk("R3 load copies period", v, 9);
    chk("R5 held output idle", 32'(pwm_out[0]), 0);
    wr(a_obs(0), 32'h55);
    rd(a_obs(0), v); chk("R9 observation write ignored", v, 9);
    rd(a_per(0), v); chk("R3 buffer readback", v, 9);
    wr(8'h08, 0);

    // R4/R5 sweep over periods, thresholds, timers, polarity
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 7; c++) begin
        int t;
        int inv;
        t = (p * 7 + c) % 5;
        inv = (p + c) & 1;
        wr(a_per(t), p); wr(a_thr(t), c);
        wr(8'h08, (32'h2 | (inv << 2)) << fb(t));
        wr(8'h08, (32'h9 | (inv << 2)) << fb(t));
        for (int j = 0; j < 2 * (p + 1) + 2; j++) begin
          int ec;
          ec = p - (j % (p + 1));
          if (t != 4) begin
            rd(a_obs(t), v); chk("R4 live count", v, ec);
          end
          chk("R5 output level", 32'(pwm_out[t]), 32'((ec <= c) ? (1 ^ inv) : inv));
          tick;
        end
      end
    end
    wr(8'h08, 0);

    // R3/R5 load held with run set: no counting, idle inverted level
    wr(a_per(3), 5); wr(a_thr(3), 2);
    wr(8'h08, 32'h7 << 16); tick;
    for (int k = 0; k < 4; k++) begin
      rd(a_obs(3), v); chk("R3 held while loading", v, 5);
      chk("R5 inverted idle", 32'(pwm_out[3]), 1);
      tick;
    end
    wr(8'h08, 32'hD << 16);
    rd(a_obs(3), v); chk("R4 starts at period", v, 5);
    chk("R5 inverted above threshold", 32'(pwm_out[3]), 1);
    tick; tick; tick;
    rd(a_obs(3), v); chk("R4 step down", v, 2);
    chk("R5 inverted at threshold", 32'(pwm_out[3]), 0);
    wr(8'h08, 0);

    // R7 buffer writes during a period
    wr(a_per(1), 3); wr(a_thr(1), 1);
    wr(8'h08, 32'h2 << 8); wr(8'h08, 32'h9 << 8);
    tick;
    wr(a_per(1), 6);
    rd(a_obs(1), v); chk("R7 period untouched", v, 1);
    wr(a_thr(1), 4);
    rd(a_obs(1), v); chk("R7 count reaches zero", v, 0);
    chk("R7 old threshold in use", 32'(pwm_out[1]), 1);
    tick;
    rd(a_obs(1), v); chk("R7 new period after refill", v, 6);
    chk("R7 new threshold after refill", 32'(pwm_out[1]), 0);
    tick; tick;
    chk("R7 new threshold reached", 32'(pwm_out[1]), 1);
    wr(8'h08, 0);

    // R6 graceful stop and R8 flags
    wr(8'h44, 32'h1F);
    rd(8'h44, v); chk("R8 clear all", v, 0);
    wr(a_per(2), 4); wr(a_thr(2), 1);
    wr(8'h08, 32'h2 << 12); wr(8'h08, 32'h9 << 12);
    tick;
    wr(8'h08, 32'h1 << 12);
    for (int k = 0; k < 6; k++) begin
      int ec;
      ec = (k < 2) ? 2 - k : 0;
      rd(a_obs(2), v); chk("R6 run-down count", v, ec);
      chk("R6 output", 32'(pwm_out[2]), (k == 1 || k == 2) ? 1 : 0);
      tick;
    end
    rd(8'h44, v); chk("R8 flag set", v, 32'h04);
    wr(8'h44, 32'h0);
    rd(8'h44, v); chk("R8 zero write keeps flag", v, 32'h04);
    wr(8'h44, 32'h04);
    rd(8'h44, v); chk("R8 one write clears", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule